// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transmitter

This block serialises 8-bit words onto a single transmit line. A system-wide clock runs the logic, and a one-cycle enable pulse sets the bit pace: it marks each period of a clock running at sixteen times the bit rate. The block holds one word in a holding register and shifts the previous word out of a separate shift register. A host writes a word whenever the holding register reports empty. The host can also see when the whole transmitter has drained, which marks the end of a message. An oversampled bit clock is brought out beside the data line. Its polarity is selectable, and it is free-running, so the line always changes on one chosen edge of it.

Two frame lengths are supported. The short frame has a low start bit, eight data bits sent least significant first, and a high stop bit. The long frame inserts a ninth bit between the data and the stop bit. The ninth bit is supplied with the word at write time, and it can be used as a parity bit or as an address marker. The holding register is not released when its word moves into the shift register. It is released a fixed two oversample periods into the first data bit of the frame.

The frame state machine has five states. IDLE holds the line high. START drives the low start bit. DATA shifts out the eight data bits. NINTH drives the extra bit of a long frame. STOP drives the high stop bit. Its transitions are:
- LOAD: from IDLE or STOP to START, when a word is waiting at a bit boundary.
- BEGIN: from START to DATA.
- EXTEND: from DATA to NINTH, in long frames.
- CLOSE: from DATA or NINTH to STOP.
- DRAIN: from STOP to IDLE, when no word is waiting.

Top module: `async_tx`

## Requirements
- R1: On reset, `txd` is 1 and both `hold_empty` and `tx_empty` are 1.
- R2: A short frame (`frame11`=0) is one 0 start bit, then `wr_data` bits 0 to 7 in that order, then one 1 stop bit. Each bit lasts exactly 16 cycles in which `tick16` is 1. Cycles with `tick16`=0 do not advance the line.
- R3: A long frame (`frame11`=1, sampled when the word is loaded) has 11 bits. The value of `wr_bit9` captured with the word is sent between data bit 7 and the stop bit.
- R4: A write with `wr_en`=1 while `hold_empty`=1 is accepted. In the following cycle, both `hold_empty` and `tx_empty` read 0.
- R5: `hold_empty` stays 0 when the word moves to the shift register and during the start bit. It returns to 1 in exactly the cycle after the 18th tick counted from the tick that began the start bit, which is two ticks into data bit 0.
- R6: `tx_empty` is 1 only while `hold_empty` is 1 and no frame is on the line. It rises in the cycle after the tick that ends a stop bit with no word waiting. An accepted write in that same cycle keeps it at 0.
- R7: A word accepted while `tx_empty`=1 is the next word sent. Its start bit begins at the next bit boundary, between 1 and 16 ticks after acceptance.
- R8: A write while `hold_empty`=0 is ignored: the word never appears on `txd`.
- R9: A word already waiting when a stop bit ends is started on the next tick, so consecutive frames start 160 (short) or 176 (long) ticks apart.
- R10: `bclk` is a free-running clock with a period of 16 ticks. `txd` changes only in the cycle where `bclk` moves to the level `clk_pol`. That edge is falling when `clk_pol`=0 and rising when `clk_pol`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample enable, one pulse per 1/16 bit period |
| clk_pol | input | 1 | Bit clock polarity select |
| frame11 | input | 1 | 1 selects the 11-bit frame |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data word to send |
| wr_bit9 | input | 1 | Ninth bit sent in long frames |
| txd | output | 1 | Serial transmit line |
| bclk | output | 1 | 1x bit clock, polarity per `clk_pol` |
| hold_empty | output | 1 | Holding register can take a word |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
Two events can fall in the same cycle: a host write and the tick that ends a stop bit with nothing waiting. The bench provokes this by timing a write to the 160th tick of a frame. It then checks three things: `tx_empty` never rises, the written word starts exactly 16 ticks later, and that word is the one decoded from the line. Separately, an exhaustive sweep of all 256 byte values in back-to-back short frames, followed by a run of long frames at the opposite clock polarity, checks the release point of `hold_empty`, the spacing between frames and the edge on which `txd` changes, frame by frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
    parameter int OVS   = 16,
    parameter int SUB_W = $clog2(OVS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pol,
    output logic [SUB_W-1:0] sub,
    output logic             bit_end,
    output logic             bclk
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2);

    logic [SUB_W-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end
    end

    assign sub     = sub_q;
    assign bit_end = tick && (sub_q == SUB_LAST);
    assign bclk    = (sub_q >= SUB_HALF) ^ pol;
endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              release_i,
    output logic              accept,
    output logic              empty,
    output logic [DATA_W-1:0] data,
    output logic              bit9
);
    logic              empty_q;
    logic [DATA_W-1:0] data_q;
    logic              bit9_q;

    assign accept = wr_en && empty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            data_q  <= '0;
            bit9_q  <= 1'b0;
        end else if (accept) begin
            empty_q <= 1'b0;
            data_q  <= wr_data;
            bit9_q  <= wr_bit9;
        end else if (release_i) begin
            empty_q <= 1'b1;
        end
    end

    assign empty = empty_q;
    assign data  = data_q;
    assign bit9  = bit9_q;

    // R8: a write refused while full leaves the stored word untouched
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !empty_q) |=> (data_q == $past(data_q) && bit9_q == $past(bit9_q)));
endmodule

// File: rtl/async_tx_fsm.sv
module async_tx_fsm
    import async_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int REL_TICK = 2,
    parameter int SUB_W    = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_end,
    input  logic [SUB_W-1:0]  sub,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_bit9,
    input  logic              frame11,
    output logic              txd,
    output logic              load,
    output logic              release_o,
    output logic              go_idle
);
    localparam int               IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [SUB_W-1:0] REL_SUB  = SUB_W'(REL_TICK - 1);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              ninth_q, ninth_d;
    logic              long_q, long_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        ninth_d = ninth_q;
        long_d  = long_q;
        load    = 1'b0;
        go_idle = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_end && !hold_empty) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    idx_d   = '0;
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (idx_q == IDX_LAST) begin
                        state_d = long_q ? ST_NINTH : ST_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        sh_d  = sh_q >> 1;
                    end
                end
            end
            ST_NINTH: begin
                if (bit_end) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (!hold_empty) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        go_idle = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) begin
            sh_d    = hold_data;
            ninth_d = hold_bit9;
            long_d  = frame11;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            ninth_q <= ninth_d;
            long_q  <= long_d;
        end
    end

    // outputs
    always_comb begin
        txd       = 1'b1;
        release_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA: begin
                txd       = sh_q[0];
                release_o = tick && (idx_q == '0) && (sub == REL_SUB);
            end
            ST_NINTH: txd = ninth_q;
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    // R5: the holding register is never released outside data bit 0
    p_release_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (state_q == ST_DATA && $past(state_q) != ST_IDLE));
endmodule

// File: rtl/async_tx.sv
module async_tx #(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int REL_TICK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              clk_pol,
    input  logic              frame11,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    output logic              txd,
    output logic              bclk,
    output logic              hold_empty,
    output logic              tx_empty
);
    localparam int SUB_W = $clog2(OVS);

    logic [SUB_W-1:0]  sub;
    logic              bit_end;
    logic              accept;
    logic              release_w;
    logic              load;
    logic              go_idle;
    logic [DATA_W-1:0] hold_data;
    logic              hold_bit9;
    logic              txe_q;

    async_tx_baud #(.OVS(OVS), .SUB_W(SUB_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .pol     (clk_pol),
        .sub     (sub),
        .bit_end (bit_end),
        .bclk    (bclk)
    );

    async_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_bit9   (wr_bit9),
        .release_i (release_w),
        .accept    (accept),
        .empty     (hold_empty),
        .data      (hold_data),
        .bit9      (hold_bit9)
    );

    async_tx_fsm #(
        .DATA_W   (DATA_W),
        .OVS      (OVS),
        .REL_TICK (REL_TICK),
        .SUB_W    (SUB_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .bit_end    (bit_end),
        .sub        (sub),
        .hold_empty (hold_empty),
        .hold_data  (hold_data),
        .hold_bit9  (hold_bit9),
        .frame11    (frame11),
        .txd        (txd),
        .load       (load),
        .release_o  (release_w),
        .go_idle    (go_idle)
    );

    // whole-transmitter empty flag; a write in the drain cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe_q <= 1'b1;
        end else if (accept) begin
            txe_q <= 1'b0;
        end else if (go_idle) begin
            txe_q <= 1'b1;
        end
    end

    assign tx_empty = txe_q;

    // R4: an accepted write drops both empty flags
    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> (!hold_empty && !tx_empty));

    // R5: moving the word into the shifter does not free the holding register
    p_no_release_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !hold_empty);

    // R6: drained transmitter implies an empty holding register and idle line
    p_drained_needs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (hold_empty && txd));

    // R10: the line only moves on the bit-clock edge toward clk_pol
    p_txd_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txd != $past(txd) && clk_pol == $past(clk_pol))
            |-> (bclk == clk_pol && $past(bclk) != clk_pol));
endmodule

// File: tb/async_tx_tb.sv
module async_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_pol = 1'b0;
    logic       frame11 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_bit9 = 1'b0;
    logic       txd, bclk, hold_empty, tx_empty;
    logic       tick16;
    logic       tick_last = 1'b0;
    logic [31:0] cyc = '0;

    int checks = 0;
    int errors = 0;
    logic [8:0] expq [0:511];
    int wp = 0;
    int rp = 0;

    // monitor state
    int   tc = 0;
    logic mon_active = 1'b0;
    int   mon_bit = 0;
    int   mbits = 10;
    logic [8:0] mon_word = '0;
    logic prev_txd = 1'b1;
    logic prev_bclk = 1'b0;
    logic prev_he = 1'b1;
    logic prev_txe = 1'b1;
    logic have_prev = 1'b0;
    int   prev_bits = 10;
    logic chain_mode = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        tick_last <= tick16;
    end
    assign tick16 = cyc[0];

    async_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .clk_pol    (clk_pol),
        .frame11    (frame11),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_bit9    (wr_bit9),
        .txd        (txd),
        .bclk       (bclk),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // line monitor: decodes frames at mid-bit, times flags in ticks
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick_last) tc = tc + 1;
            if (txd !== prev_txd)
                chk(bclk == clk_pol && prev_bclk == !clk_pol, "R10 txd edge vs bclk",
                    int'(bclk), int'(clk_pol));
            if (!mon_active && prev_txd && !txd) begin
                if (chain_mode && have_prev)
                    chk(tc == prev_bits * 16, "R9 frame spacing", tc, prev_bits * 16);
                tc = 0;
                have_prev = 1'b1;
                mbits = frame11 ? 11 : 10;
                prev_bits = mbits;
            end
            if (hold_empty && !prev_he)
                chk(tc == 18, "R5 hold_empty release tick", tc, 18);
            if (tx_empty && !prev_txe)
                chk(tc == mbits * 16, "R6 tx_empty rise tick", tc, mbits * 16);
            if (bclk != prev_bclk && bclk == !clk_pol) begin
                if (!mon_active) begin
                    if (!txd) begin
                        mon_active = 1'b1;
                        mon_bit = 0;
                        mon_word = '0;
                    end
                end else begin
                    mon_bit = mon_bit + 1;
                    if (mon_bit <= 8) mon_word[mon_bit-1] = txd;
                    else if (mon_bit == 9 && mbits == 11) mon_word[8] = txd;
                    if (mon_bit == mbits - 1) begin
                        mon_active = 1'b0;
                        chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
                        if (rp >= wp) begin
                            chk(1'b0, "R8 unexpected frame", int'(mon_word), -1);
                        end else begin
                            chk(mon_word[7:0] == expq[rp][7:0], "R2 data bits",
                                int'(mon_word[7:0]), int'(expq[rp][7:0]));
                            if (mbits == 11)
                                chk(mon_word[8] == expq[rp][8], "R3 ninth bit",
                                    int'(mon_word[8]), int'(expq[rp][8]));
                            rp++;
                        end
                    end
                end
            end
        end
        prev_txd  = txd;
        prev_bclk = bclk;
        prev_he   = hold_empty;
        prev_txe  = tx_empty;
    end

    task automatic do_write(input logic [7:0] d, input logic b9, input logic want_accept);
        logic acc;
        logic was_txe;
        @(negedge clk); #1;
        acc = hold_empty;
        was_txe = tx_empty;
        wr_en = 1'b1; wr_data = d; wr_bit9 = b9;
        @(negedge clk); #1;
        wr_en = 1'b0;
        if (acc) begin
            expq[wp] = {b9, d};
            wp++;
            chk(hold_empty == 1'b0, "R4 hold_empty cleared", int'(hold_empty), 0);
            if (was_txe)
                chk(tx_empty == 1'b0, "R4 tx_empty cleared", int'(tx_empty), 0);
        end
        if (want_accept)
            chk(acc == 1'b1, "R4 write accepted", int'(acc), 1);
    endtask

    task automatic wait_hold();
        while (!hold_empty) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic drain();
        while (!(tx_empty && rp == wp)) begin
            @(negedge clk); #1;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t;
        repeat (5) @(negedge clk);
        #1;
        chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        chk(txd == 1'b1 && tx_empty == 1'b1, "R1 idle line stays high", int'(txd), 1);

        // R2/R9/R10: exhaustive short-frame sweep, positive polarity, back to back
        chain_mode = 1'b1;
        for (int b = 0; b < 256; b++) begin
            wait_hold();
            do_write(8'(b), 1'b0, 1'b1);
            if (b == 5) begin
                // R8: a second write while full must vanish from the line
                do_write(8'hC3, 1'b0, 1'b0);
                chk(hold_empty == 1'b0, "R8 refused write keeps full", int'(hold_empty), 0);
            end
        end
        drain();
        chain_mode = 1'b0;
        chk(txd == 1'b1 && hold_empty == 1'b1, "R6 drained state", int'(txd), 1);
        chk(rp == wp, "R2 all words sent", rp, wp);

        // R7: a word written into a drained transmitter goes next, within a bit
        do_write(8'h5A, 1'b0, 1'b1);
        t = 0;
        while (txd) begin
            @(negedge clk);
            if (tick_last) t++;
            #1;
        end
        chk(t >= 1 && t <= 16, "R7 start latency ticks", t, 16);
        drain();

        // R3/R10: long frames, negative polarity, chained
        clk_pol = 1'b1;
        frame11 = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        chain_mode = 1'b1;
        have_prev = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 11);
            wait_hold();
            do_write(d, (^d) ^ 1'(i), 1'b1);
        end
        drain();
        chain_mode = 1'b0;
        chk(rp == wp, "R3 all long words sent", rp, wp);

        // R6: write lands in the very cycle the stop bit ends
        clk_pol = 1'b0;
        frame11 = 1'b0;
        repeat (40) @(negedge clk);
        #1;
        do_write(8'h81, 1'b0, 1'b1);
        while (txd) begin
            @(negedge clk); #1;
        end
        while (!(tc == 159 && tick16 == 1'b1)) begin
            @(negedge clk); #1;
        end
        chk(hold_empty == 1'b1, "R6 hold free before collision", int'(hold_empty), 1);
        wr_en = 1'b1; wr_data = 8'h7E; wr_bit9 = 1'b0;
        expq[wp] = 9'h07E;
        wp++;
        @(negedge clk); #1;
        wr_en = 1'b0;
        chk(tx_empty == 1'b0, "R6 tx_empty held low on collision", int'(tx_empty), 0);
        t = 0;
        while (txd) begin
            @(negedge clk);
            if (tick_last) t++;
            if (tx_empty) chk(1'b0, "R6 tx_empty rose during collision", 1, 0);
            #1;
        end
        chk(t == 16, "R7 collided word starts next boundary", t, 16);
        drain();
        chk(rp == wp && tx_empty == 1'b1, "R6 final drain", rp, wp);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule